// File: doc/BRIEF.md
# Handset Voice Gain and Side-Tone Mixer

This block processes the linear 16-bit PCM voice samples of a handset. On every sample strobe it takes one transmit sample and one receive sample. The transmit sample is boosted by a programmable amount. The receive sample is cut by a programmable amount. A side-tone path can also feed a scaled copy of the caller's own voice back into the earpiece.

The side-tone copy is taken from the raw transmit input, before the transmit boost. It is added to the receive sample after the receive cut, so neither path gain changes the side-tone level. Each gain is a Q2.14 coefficient chosen from a small table by a 3-bit code. The product is rounded, and both outputs saturate to the signed 16-bit range.

Gain codes live in two byte-wide registers behind a plain write port. Writes go into a staging copy. That copy is committed to the datapath only on a sample strobe, so no sample ever sees a half-written configuration.

Top module: `hs_voice_mixer`

## Requirements
- R1: After reset, `tx_out` and `rx_out` are 0 and `out_valid` is low. The transmit and receive gains are 0 dB, the side-tone gain code is 3 (0 dB) and the side-tone is disabled, so the first sample passes through both paths unchanged.
- R2: Register map:
  - Address 0 holds the transmit code in data bits [2:0] and the receive code in bits [6:4].
  - Address 1 holds the side-tone code in bits [2:0] and the side-tone enable in bit 7.
  - Other bits of a written byte are ignored.
- R3: For transmit code n (0..7) the coefficient is round(16384·10^(n/20)), a boost of n dB. The transmit output is floor((x·c + 8192)/16384), saturated to 16 bits.
- R4: For receive code n (0..7) the coefficient is round(16384·10^(−n/20)), a cut of n dB. It is applied with the same rounding rule as R3.
- R5: For side-tone code n (0..6) the gain is (n−3)·3.32 dB, with coefficient round(16384·10^(gain/20)). Code 7 gives the same gain as code 6 (+9.96 dB).
- R6: The side-tone term is the rounded product of the transmit input (before the transmit gain) and the side-tone coefficient. It is added to the rounded receive product only when the enable bit is 1.
- R7: The receive output saturates: a sum above 32767 yields 32767, and a sum below −32768 yields −32768.
- R8: The transmit output saturates the same way when the boost exceeds the 16-bit range.
- R9: A sample is captured on the clock edge where `smp_stb` is high. `tx_out` and `rx_out` update on the next edge, and `out_valid` is high for exactly that one cycle. Both outputs hold their values between results.
- R10: Each strobe edge commits the register values written before that cycle. A write in the same cycle as a strobe affects only later strobes.
- R11: A write to address 2 or 3 has no effect on any gain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| smp_stb | input | 1 | Sample strobe, one cycle per sample |
| tx_in | input | 16 | Transmit sample, signed |
| rx_in | input | 16 | Receive sample, signed |
| tx_out | output | 16 | Scaled transmit sample |
| rx_out | output | 16 | Scaled receive sample plus side-tone |
| out_valid | output | 1 | One-cycle pulse marking new outputs |

## Verification
The assertions rely on the sample inputs being meaningful only on strobe cycles. They also assume the gain registers change only through the write port, so the committed gain codes can be tied to the outputs one cycle later. The stimulus respects this by leaving at least two idle cycles after each strobe before the next one. Writes are placed either well before a strobe or, for the commit-ordering case, in the same cycle as the strobe. Random samples are mixed with full-scale positive and negative values so that the side-tone sum and the transmit boost reach both saturation limits.

// File: rtl/hsg_pkg.sv
`timescale 1ns/1ps
package hsg_pkg;
  localparam int GW        = 3;
  localparam int CW        = 16;
  localparam int FRAC      = 14;
  localparam int ADDR_G1   = 0;
  localparam int ADDR_G2   = 1;
  localparam int TX_LSB    = 0;
  localparam int RX_LSB    = 4;
  localparam int ST_LSB    = 0;
  localparam int ST_EN_BIT = 7;
  localparam logic [GW-1:0] ST_UNITY = 3'd3;

  function automatic logic [CW-1:0] tx_coef(input logic [GW-1:0] code);
    case (code)
      3'd0:    tx_coef = 16'd16384;
      3'd1:    tx_coef = 16'd18383;
      3'd2:    tx_coef = 16'd20626;
      3'd3:    tx_coef = 16'd23143;
      3'd4:    tx_coef = 16'd25967;
      3'd5:    tx_coef = 16'd29135;
      3'd6:    tx_coef = 16'd32690;
      default: tx_coef = 16'd36679;
    endcase
  endfunction

  function automatic logic [CW-1:0] rx_coef(input logic [GW-1:0] code);
    case (code)
      3'd0:    rx_coef = 16'd16384;
      3'd1:    rx_coef = 16'd14602;
      3'd2:    rx_coef = 16'd13014;
      3'd3:    rx_coef = 16'd11599;
      3'd4:    rx_coef = 16'd10338;
      3'd5:    rx_coef = 16'd9213;
      3'd6:    rx_coef = 16'd8211;
      default: rx_coef = 16'd7318;
    endcase
  endfunction

  function automatic logic [CW-1:0] st_coef(input logic [GW-1:0] code);
    case (code)
      3'd0:    st_coef = 16'd5205;
      3'd1:    st_coef = 16'd7628;
      3'd2:    st_coef = 16'd11179;
      3'd3:    st_coef = 16'd16384;
      3'd4:    st_coef = 16'd24012;
      3'd5:    st_coef = 16'd35190;
      default: st_coef = 16'd51573;
    endcase
  endfunction
endpackage

// File: rtl/hsg_regs.sv
`timescale 1ns/1ps
module hsg_regs
  import hsg_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          smp_stb,
  output logic [GW-1:0] act_tx,
  output logic [GW-1:0] act_rx,
  output logic [GW-1:0] act_st,
  output logic          act_en
);
  logic [GW-1:0] sh_tx, sh_rx, sh_st;
  logic          sh_en;
  logic [GW-1:0] sh_tx_d, sh_rx_d, sh_st_d;
  logic          sh_en_d;
  logic          hit_g1, hit_g2;

  assign hit_g1 = wr_en && (wr_addr == AW'(ADDR_G1));
  assign hit_g2 = wr_en && (wr_addr == AW'(ADDR_G2));

  always_comb begin
    sh_tx_d = sh_tx;
    sh_rx_d = sh_rx;
    sh_st_d = sh_st;
    sh_en_d = sh_en;
    if (hit_g1) begin
      sh_tx_d = wr_data[TX_LSB +: GW];
      sh_rx_d = wr_data[RX_LSB +: GW];
    end
    if (hit_g2) begin
      sh_st_d = wr_data[ST_LSB +: GW];
      sh_en_d = wr_data[ST_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_tx <= '0;
      sh_rx <= '0;
      sh_st <= ST_UNITY;
      sh_en <= 1'b0;
    end else begin
      sh_tx <= sh_tx_d;
      sh_rx <= sh_rx_d;
      sh_st <= sh_st_d;
      sh_en <= sh_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_tx <= '0;
      act_rx <= '0;
      act_st <= ST_UNITY;
      act_en <= 1'b0;
    end else if (smp_stb) begin
      act_tx <= sh_tx;
      act_rx <= sh_rx;
      act_st <= sh_st;
      act_en <= sh_en;
    end
  end

  // R10: committed settings move only on a strobe, and then to the staged copy
  p_hold_between_strobes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(act_tx) && $stable(act_rx) && $stable(act_st) && $stable(act_en)));
  p_commit_on_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> (act_tx == $past(sh_tx) && act_rx == $past(sh_rx)
                 && act_st == $past(sh_st) && act_en == $past(sh_en)));
endmodule

// File: rtl/hsg_scale.sv
`timescale 1ns/1ps
module hsg_scale #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter int OW   = 19
) (
  input  logic signed [DW-1:0] x,
  input  logic        [CW-1:0] coef,
  output logic signed [OW-1:0] y
);
  localparam int PW = DW + CW + 1;
  logic signed [CW:0]   cs;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] prod_r;

  assign cs     = {1'b0, coef};
  assign prod   = PW'(x) * PW'(cs);
  assign prod_r = prod + PW'(1 << (FRAC - 1));
  assign y      = OW'(prod_r >>> FRAC);
endmodule

// File: rtl/hsg_sat.sv
`timescale 1ns/1ps
module hsg_sat #(
  parameter int IW = 20,
  parameter int OW = 16
) (
  input  logic signed [IW-1:0] v,
  output logic signed [OW-1:0] y
);
  localparam logic signed [IW-1:0] HI = IW'((2 ** (OW - 1)) - 1);
  localparam logic signed [IW-1:0] LO = -HI - IW'(1);

  always_comb begin
    if (v > HI)      y = HI[OW-1:0];
    else if (v < LO) y = LO[OW-1:0];
    else             y = v[OW-1:0];
  end
endmodule

// File: rtl/hs_voice_mixer.sv
`timescale 1ns/1ps
module hs_voice_mixer
  import hsg_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 smp_stb,
  input  logic signed [DW-1:0] tx_in,
  input  logic signed [DW-1:0] rx_in,
  output logic signed [DW-1:0] tx_out,
  output logic signed [DW-1:0] rx_out,
  output logic                 out_valid
);
  localparam int PW = DW + 3;
  localparam int SW = PW + 1;
  localparam logic signed [SW-1:0] SUM_MAX = SW'((2 ** (DW - 1)) - 1);
  localparam logic signed [SW-1:0] SUM_MIN = -SUM_MAX - SW'(1);
  localparam logic signed [DW-1:0] OUT_MAX = SUM_MAX[DW-1:0];
  localparam logic signed [DW-1:0] OUT_MIN = SUM_MIN[DW-1:0];

  logic [1:0] rsync;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_s_n = rsync[1];

  logic [GW-1:0] act_tx, act_rx, act_st;
  logic          act_en;

  hsg_regs #(.AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .smp_stb (smp_stb),
    .act_tx  (act_tx),
    .act_rx  (act_rx),
    .act_st  (act_st),
    .act_en  (act_en)
  );

  logic signed [DW-1:0] tx_q, rx_q;
  logic                 stb_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= smp_stb;
      if (smp_stb) begin
        tx_q <= tx_in;
        rx_q <= rx_in;
      end
    end
  end

  logic signed [PW-1:0] tx_full, rx_full, st_full, st_gated;
  logic signed [SW-1:0] rx_sum;
  logic signed [DW-1:0] tx_sat, rx_sat;

  hsg_scale #(.DW(DW), .CW(CW), .FRAC(FRAC), .OW(PW)) u_tx_gain (
    .x(tx_q), .coef(tx_coef(act_tx)), .y(tx_full));
  hsg_scale #(.DW(DW), .CW(CW), .FRAC(FRAC), .OW(PW)) u_rx_gain (
    .x(rx_q), .coef(rx_coef(act_rx)), .y(rx_full));
  hsg_scale #(.DW(DW), .CW(CW), .FRAC(FRAC), .OW(PW)) u_st_gain (
    .x(tx_q), .coef(st_coef(act_st)), .y(st_full));

  assign st_gated = act_en ? st_full : '0;
  assign rx_sum   = SW'(rx_full) + SW'(st_gated);

  hsg_sat #(.IW(SW), .OW(DW)) u_tx_sat (.v(SW'(tx_full)), .y(tx_sat));
  hsg_sat #(.IW(SW), .OW(DW)) u_rx_sat (.v(rx_sum),       .y(rx_sat));

  logic signed [DW-1:0] tx_out_d, rx_out_d;

  always_comb begin
    tx_out_d = tx_out;
    rx_out_d = rx_out;
    if (stb_q) begin
      tx_out_d = tx_sat;
      rx_out_d = rx_sat;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      tx_out    <= '0;
      rx_out    <= '0;
      out_valid <= 1'b0;
    end else begin
      tx_out    <= tx_out_d;
      rx_out    <= rx_out_d;
      out_valid <= stb_q;
    end
  end

  // R9: one result pulse two edges after each strobe, outputs held otherwise
  p_valid_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    smp_stb |=> ##1 out_valid);
  p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !smp_stb |=> ##1 !out_valid);
  p_outputs_hold_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !stb_q |=> ($stable(tx_out) && $stable(rx_out)));
  // R7: receive sum clamps at both rails
  p_rx_clamp_hi_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (stb_q && rx_sum > SUM_MAX) |=> rx_out == OUT_MAX);
  p_rx_clamp_lo_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (stb_q && rx_sum < SUM_MIN) |=> rx_out == OUT_MIN);
  // R3: code 0 on transmit is unity
  p_tx_unity_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (stb_q && act_tx == '0) |=> tx_out == $past(tx_q));
  // R6: with side-tone off and receive at 0 dB the receive sample passes unchanged
  p_st_off_pass_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (stb_q && !act_en && act_rx == '0) |=> rx_out == $past(rx_q));
endmodule

// File: tb/hs_voice_mixer_bench.sv
`timescale 1ns/1ps
module hs_voice_mixer_bench;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [1:0]        wr_addr;
  logic [7:0]        wr_data;
  logic              smp_stb;
  logic signed [15:0] tx_in, rx_in;
  logic signed [15:0] tx_out, rx_out;
  logic              out_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  int m_sh_tx, m_sh_rx, m_sh_st, m_sh_en;
  int m_ac_tx, m_ac_rx, m_ac_st, m_ac_en;

  always #5 clk = ~clk;

  hs_voice_mixer u_hs_voice_mixer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .smp_stb(smp_stb), .tx_in(tx_in), .rx_in(rx_in),
    .tx_out(tx_out), .rx_out(rx_out), .out_valid(out_valid));

  function automatic int coef_db(real db);
    return int'(16384.0 * (10.0 ** (db / 20.0)));
  endfunction

  function automatic int c_tx(int code); return coef_db(real'(code)); endfunction
  function automatic int c_rx(int code); return coef_db(-real'(code)); endfunction
  function automatic int c_st(int code);
    int k = (code > 6) ? 6 : code;
    return coef_db(real'(k - 3) * 3.32);
  endfunction

  function automatic int scl(int x, int c);
    longint p = longint'(x) * longint'(c) + 64'sd8192;
    return int'(p >>> 14);
  endfunction

  function automatic int sat16(int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_write(int a, int d);
    if (a == 0) begin m_sh_tx = d & 7; m_sh_rx = (d >> 4) & 7; end
    else if (a == 1) begin m_sh_st = d & 7; m_sh_en = (d >> 7) & 1; end
  endtask

  task automatic reg_wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  // drive one sample; optional write in the same cycle; checks outputs
  task automatic sample(int tx, int rx, bit do_wr, int a, int d, string req);
    int etx, erx;
    @(negedge clk);
    smp_stb = 1'b1; tx_in = 16'(tx); rx_in = 16'(rx);
    if (do_wr) begin wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d); end
    m_ac_tx = m_sh_tx; m_ac_rx = m_sh_rx; m_ac_st = m_sh_st; m_ac_en = m_sh_en;
    if (do_wr) model_write(a, d);
    etx = sat16(scl(tx, c_tx(m_ac_tx)));
    erx = sat16(scl(rx, c_rx(m_ac_rx)) + (m_ac_en != 0 ? scl(tx, c_st(m_ac_st)) : 0));
    @(negedge clk);
    smp_stb = 1'b0; wr_en = 1'b0;
    chk("R9 valid low before result", int'(out_valid), 0);
    @(negedge clk);
    chk("R9 valid pulse", int'(out_valid), 1);
    chk({req, " tx_out"}, int'(tx_out), etx);
    chk({req, " rx_out"}, int'(rx_out), erx);
    @(negedge clk);
    chk("R9 valid one cycle", int'(out_valid), 0);
    chk("R9 tx_out held", int'(tx_out), etx);
    chk("R9 rx_out held", int'(rx_out), erx);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int vtx, vrx;
    process::self().srandom(32'd1607);
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    smp_stb = 1'b0; tx_in = '0; rx_in = '0;
    m_sh_tx = 0; m_sh_rx = 0; m_sh_st = 3; m_sh_en = 0;
    m_ac_tx = 0; m_ac_rx = 0; m_ac_st = 3; m_ac_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 tx_out reset", int'(tx_out), 0);
    chk("R1 rx_out reset", int'(rx_out), 0);
    chk("R1 valid reset", int'(out_valid), 0);
    sample(1234, -500, 0, 0, 0, "R1 default passthrough");

    // R3/R4 every code, R2 field positions
    for (int n = 0; n < 8; n++) begin
      reg_wr(0, (n << 4) | (7 - n) | 8'h88);
      sample(20001 - n * 3001, -17777 + n * 4001, 0, 0, 0, "R3 R4 R2 gain codes");
    end
    // R8 transmit saturation both rails
    reg_wr(0, 8'h07);
    sample(32767, 100, 0, 0, 0, "R8 tx clamp high");
    sample(-32768, 100, 0, 0, 0, "R8 tx clamp low");
    // R5/R6 side-tone codes incl. code 7, tapped before tx gain
    for (int n = 0; n < 8; n++) begin
      reg_wr(1, 8'h80 | n | 8'h70);
      sample(9000 - n * 2500, 3000, 0, 0, 0, "R5 R6 side-tone codes");
    end
    // R7 receive saturation
    reg_wr(0, 8'h00);
    reg_wr(1, 8'h86);
    sample(32767, 32767, 0, 0, 0, "R7 rx clamp high");
    sample(-32768, -32768, 0, 0, 0, "R7 rx clamp low");
    // R6 enable bit off removes side-tone
    reg_wr(1, 8'h06);
    sample(30000, 1000, 0, 0, 0, "R6 side-tone disabled");
    // R11 writes to unused addresses
    reg_wr(2, 8'hFF);
    reg_wr(3, 8'hFF);
    sample(12345, -12345, 0, 0, 0, "R11 unused address");
    // R10 write in the strobe cycle applies only later
    sample(10000, 10000, 1, 0, 8'h77, "R10 same-cycle write not yet");
    sample(10000, 10000, 0, 0, 0, "R10 write applied next strobe");

    // constrained random
    for (int i = 0; i < 300; i++) begin
      int sel = int'($urandom_range(0, 9));
      if (sel < 3) reg_wr(int'($urandom_range(0, 3)), int'($urandom_range(0, 255)));
      vtx = int'($urandom_range(0, 65535)) - 32768;
      vrx = int'($urandom_range(0, 65535)) - 32768;
      if (sel == 4) vtx = 32767;
      if (sel == 5) vtx = -32768;
      if (sel == 9)
        sample(vtx, vrx, 1, int'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
               "R10 R7 random with strobe write");
      else
        sample(vtx, vrx, 0, 0, 0, "R3 R4 R6 R7 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule